// File: doc/BRIEF.md
# Set-Associative Cache Tag Lookup

This unit holds the tag, status and data storage of a 128-set cache with four or eight ways (the `NUM_WAYS` parameter picks one). A lookup is combinational. Seven bits of the virtual address pick one set. Twenty bits of the physical address form the tag reference, which is compared against every way of that set. The unit returns a combined hit, the number of the way that hit, and one 64-bit doubleword of that way's line. Addresses use big-endian bit numbering: bit 0 is the most significant bit of the 32-bit word.

Reset leaves the per-line status bits (valid, dirty, lock) untouched, so their contents after power-up are unknown. Before lookups can hit, software must run an invalidate sweep. The sweep clears the status of one set per clock and walks from set 0 to set 127. Only after one full sweep since reset does an enable request switch the cache on. Tags, lines and status are written through a one-cycle update port. Line fill, victim choice and write-back belong to neighbouring logic.

Top module: `tag_lookup_unit`

## Requirements
- R1: The set index is lookup virtual address bits 20..26 (bit 0 = MSB, bit 20 = index MSB). Bits 0..19 and 29..31 of the virtual address have no effect on the result.
- R2: A way hits only when its stored tag equals physical address bits 0..19 and its valid bit is set. A matching tag in a line whose valid bit is clear gives a miss.
- R3: `hit` is the OR of all per-way hits and `hit_way` gives the number of the hitting way. On a miss, `rd_data` and `hit_way` are zero.
- R4: Virtual address bits 27..28, read as a 2-bit number n (bit 27 = MSB), select doubleword n of the hit line. Doubleword n sits at bits [64n+63:64n] of the 256-bit update line.
- R5: When more than one way hits, `hit_way` and `rd_data` come from the lowest-numbered hitting way and `mhit_err` is 1. Otherwise `mhit_err` is 0.
- R6: A cycle with `inv_start` high while idle starts a sweep. `inv_busy` is then high for exactly 128 consecutive cycles, starting the next cycle. `inv_done` is high for exactly the one cycle after that, and every line is invalid once the sweep ends.
- R7: `hit` and `mhit_err` are 0 while `cache_on` is 0 or `inv_busy` is 1.
- R8: An `en_req` pulse sets `cache_on` on the next cycle only if a sweep has completed since the last reset. Before that, the pulse is ignored.
- R9: A `dis_req` pulse clears `cache_on` on the next cycle, and it wins over an `en_req` in the same cycle.
- R10: After reset, `cache_on`, `inv_busy` and `inv_done` are 0, and the record of a completed sweep is cleared.
- R11: `inv_start` asserted while a sweep is busy is ignored and does not lengthen the sweep.
- R12: An update with `upd_we` high writes tag, line and status into the addressed way and set. A lookup in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (control state only) |
| lk_vaddr | input | 32 | Lookup virtual address, bit 0 = MSB |
| lk_paddr | input | 32 | Lookup physical address, bit 0 = MSB |
| upd_we | input | 1 | Update write strobe |
| upd_way | input | $clog2(NUM_WAYS) | Way written by the update |
| upd_vaddr | input | 32 | Update virtual address (set index) |
| upd_paddr | input | 32 | Update physical address (tag) |
| upd_valid | input | 1 | Valid bit to write |
| upd_dirty | input | 1 | Dirty bit to write |
| upd_lock | input | 1 | Lock bit to write |
| upd_line | input | 256 | Four doublewords of line data |
| inv_start | input | 1 | Start an invalidate sweep |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| hit | output | 1 | Combined hit |
| hit_way | output | $clog2(NUM_WAYS) | Index of the returned way |
| rd_data | output | 64 | Selected doubleword |
| mhit_err | output | 1 | More than one way hit |
| inv_busy | output | 1 | Sweep in progress |
| inv_done | output | 1 | One-cycle sweep completion pulse |
| cache_on | output | 1 | Lookups enabled |

## Verification
The assertions assume that `inv_start`, `en_req` and `dis_req` are single-cycle pulses and that the update port stays quiet while a sweep runs. One assertion watches the last of these, because a write landing in the middle of a sweep would leave a line valid that the sweep was supposed to clear. The stimulus writes distinct tags into every way of every set. Duplicate tags appear only in one deliberate fault case that checks the multi-hit flag. Update writes are issued only while `inv_busy` is low, and every request is raised for exactly one cycle.

// File: rtl/tag_lookup_pkg.sv
package tag_lookup_pkg;

    localparam int ADDR_W   = 32;
    localparam int TAG_W    = 20;
    localparam int INDEX_W  = 7;
    localparam int NUM_SETS = 1 << INDEX_W;
    localparam int DW_W     = 64;
    localparam int LINE_DW  = 4;
    localparam int DWSEL_W  = $clog2(LINE_DW);
    localparam int LINE_W   = DW_W * LINE_DW;

    // Big-endian numbered address: element 0 is the most significant bit.
    typedef logic [0:ADDR_W-1]               addr_t;
    typedef logic [TAG_W-1:0]                tag_t;
    typedef logic [INDEX_W-1:0]              index_t;
    typedef logic [DWSEL_W-1:0]              dwsel_t;
    typedef logic [DW_W-1:0]                 dword_t;
    typedef logic [LINE_DW-1:0][DW_W-1:0]    line_t;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic lock;
    } line_stat_t;

    function automatic index_t set_of(addr_t a);
        return a[20:26];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[0:19];
    endfunction

    function automatic dwsel_t dw_of(addr_t a);
        return a[27:28];
    endfunction

endpackage

// File: rtl/tag_store.sv
module tag_store
    import tag_lookup_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                           clk,
    input  logic                           upd_we,
    input  logic [WAY_W-1:0]               upd_way,
    input  index_t                         upd_set,
    input  tag_t                           upd_tag,
    input  line_stat_t                     upd_stat,
    input  line_t                          upd_line,
    input  logic                           clr_en,
    input  index_t                         clr_set,
    input  index_t                         rd_set,
    output tag_t       [NUM_WAYS-1:0]      rd_tag,
    output line_stat_t [NUM_WAYS-1:0]      rd_stat,
    output line_t      [NUM_WAYS-1:0]      rd_line
);

    // Storage carries no reset: status is meaningful only after a sweep.
    tag_t       tag_mem  [NUM_SETS][NUM_WAYS];
    line_stat_t stat_mem [NUM_SETS][NUM_WAYS];
    line_t      line_mem [NUM_SETS][NUM_WAYS];

    always_ff @(posedge clk) begin
        if (upd_we) begin
            tag_mem[upd_set][upd_way]  <= upd_tag;
            stat_mem[upd_set][upd_way] <= upd_stat;
            line_mem[upd_set][upd_way] <= upd_line;
        end
        // The sweep clear comes last so it overrides a same-cycle status write.
        if (clr_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                stat_mem[clr_set][w] <= '0;
            end
        end
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign rd_tag[w]  = tag_mem[rd_set][w];
        assign rd_stat[w] = stat_mem[rd_set][w];
        assign rd_line[w] = line_mem[rd_set][w];
    end

endmodule

// File: rtl/hit_select.sv
module hit_select
    import tag_lookup_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                           gate_open,
    input  tag_t                           ref_tag,
    input  dwsel_t                         dw_sel,
    input  tag_t       [NUM_WAYS-1:0]      rd_tag,
    input  line_stat_t [NUM_WAYS-1:0]      rd_stat,
    input  line_t      [NUM_WAYS-1:0]      rd_line,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way,
    output logic                           mhit,
    output dword_t                         data
);

    logic [NUM_WAYS-1:0] way_hit;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign way_hit[w] = gate_open && rd_stat[w].valid && (rd_tag[w] == ref_tag);
    end

    line_t sel_line;

    always_comb begin
        hit_way = '0;
        // Walk downward so the lowest-numbered hitting way is kept.
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        int unsigned n_hits;
        n_hits = 0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            n_hits += 32'(way_hit[w]);
        end
        mhit = (n_hits > 1);
    end

    assign hit      = |way_hit;
    assign sel_line = rd_line[hit_way];
    assign data     = hit ? sel_line[dw_sel] : '0;

endmodule

// File: rtl/inv_sequencer.sv
module inv_sequencer
    import tag_lookup_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output logic   busy,
    output logic   done,
    output logic   swept,
    output logic   clr_en,
    output index_t clr_set
);

    localparam index_t LAST_SET = index_t'(NUM_SETS - 1);

    index_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            swept <= 1'b0;
            cnt   <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                cnt <= cnt + index_t'(1);
                if (cnt == LAST_SET) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    swept <= 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    assign clr_en  = busy;
    assign clr_set = cnt;

endmodule

// File: rtl/enable_gate.sv
module enable_gate (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic dis_req,
    input  logic swept,
    output logic on
);

    always_ff @(posedge clk) begin
        if (rst) begin
            on <= 1'b0;
        end else if (dis_req) begin
            on <= 1'b0;
        end else if (en_req && swept) begin
            on <= 1'b1;
        end
    end

endmodule

// File: rtl/tag_lookup_unit.sv
module tag_lookup_unit
    import tag_lookup_pkg::*;
#(
    parameter int NUM_WAYS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [0:31]                   lk_vaddr,
    input  logic [0:31]                   lk_paddr,
    input  logic                          upd_we,
    input  logic [$clog2(NUM_WAYS)-1:0]   upd_way,
    input  logic [0:31]                   upd_vaddr,
    input  logic [0:31]                   upd_paddr,
    input  logic                          upd_valid,
    input  logic                          upd_dirty,
    input  logic                          upd_lock,
    input  logic [255:0]                  upd_line,
    input  logic                          inv_start,
    input  logic                          en_req,
    input  logic                          dis_req,
    output logic                          hit,
    output logic [$clog2(NUM_WAYS)-1:0]   hit_way,
    output logic [63:0]                   rd_data,
    output logic                          mhit_err,
    output logic                          inv_busy,
    output logic                          inv_done,
    output logic                          cache_on
);

    tag_t       [NUM_WAYS-1:0] rd_tag;
    line_stat_t [NUM_WAYS-1:0] rd_stat;
    line_t      [NUM_WAYS-1:0] rd_line;

    logic       swept;
    logic       clr_en;
    index_t     clr_set;
    line_stat_t upd_stat;
    logic       gate_open;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{lk_vaddr[0:19], lk_vaddr[29:31],
                                lk_paddr[20:31], upd_vaddr[0:19],
                                upd_vaddr[27:31], upd_paddr[20:31]};

    assign upd_stat  = '{valid: upd_valid, dirty: upd_dirty, lock: upd_lock};
    assign gate_open = cache_on && !inv_busy;

    inv_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (inv_start),
        .busy    (inv_busy),
        .done    (inv_done),
        .swept   (swept),
        .clr_en  (clr_en),
        .clr_set (clr_set)
    );

    enable_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .en_req  (en_req),
        .dis_req (dis_req),
        .swept   (swept),
        .on      (cache_on)
    );

    tag_store #(.NUM_WAYS(NUM_WAYS)) u_store (
        .clk      (clk),
        .upd_we   (upd_we),
        .upd_way  (upd_way),
        .upd_set  (set_of(upd_vaddr)),
        .upd_tag  (tag_of(upd_paddr)),
        .upd_stat (upd_stat),
        .upd_line (line_t'(upd_line)),
        .clr_en   (clr_en),
        .clr_set  (clr_set),
        .rd_set   (set_of(lk_vaddr)),
        .rd_tag   (rd_tag),
        .rd_stat  (rd_stat),
        .rd_line  (rd_line)
    );

    hit_select #(.NUM_WAYS(NUM_WAYS)) u_sel (
        .gate_open (gate_open),
        .ref_tag   (tag_of(lk_paddr)),
        .dw_sel    (dw_of(lk_vaddr)),
        .rd_tag    (rd_tag),
        .rd_stat   (rd_stat),
        .rd_line   (rd_line),
        .hit       (hit),
        .hit_way   (hit_way),
        .mhit      (mhit_err),
        .data      (rd_data)
    );

endmodule

// File: rtl/tag_lookup_checker.sv
module tag_lookup_checker (
    input logic clk,
    input logic rst,
    input logic hit,
    input logic mhit_err,
    input logic inv_busy,
    input logic inv_done,
    input logic cache_on,
    input logic dis_req,
    input logic upd_we
);

    logic       seen_done;
    logic [8:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_done <= 1'b0;
            busy_len  <= '0;
        end else begin
            if (inv_done) seen_done <= 1'b1;
            busy_len <= inv_busy ? busy_len + 9'd1 : 9'd0;
        end
    end

    AST_HIT_GATED: assert property (@(posedge clk) disable iff (rst)
        (!cache_on || inv_busy) |-> (!hit && !mhit_err)); // R7

    AST_MHIT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        mhit_err |-> hit); // R5

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        inv_done |-> ($past(inv_busy) && !inv_busy)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        inv_done |=> !inv_done); // R6

    AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(inv_busy) |-> (busy_len == 9'd128)); // R6

    AST_ENABLE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(cache_on) |-> seen_done); // R8

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
        dis_req |=> !cache_on); // R9

    AST_NO_UPDATE_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
        inv_busy |-> !upd_we); // R12

endmodule

bind tag_lookup_unit tag_lookup_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .mhit_err (mhit_err),
    .inv_busy (inv_busy),
    .inv_done (inv_done),
    .cache_on (cache_on),
    .dis_req  (dis_req),
    .upd_we   (upd_we)
);

// File: tb/tag_lookup_unit_test.sv
module tag_lookup_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS       = 4;
    localparam int WW         = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [0:31]   lk_vaddr, lk_paddr, upd_vaddr, upd_paddr;
    logic          upd_we, upd_valid, upd_dirty, upd_lock;
    logic [WW-1:0] upd_way;
    logic [255:0]  upd_line;
    logic          inv_start, en_req, dis_req;
    logic          hit, mhit_err, inv_busy, inv_done, cache_on;
    logic [WW-1:0] hit_way;
    logic [63:0]   rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    tag_lookup_unit #(.NUM_WAYS(WAYS)) uut (
        .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_paddr(lk_paddr),
        .upd_we(upd_we), .upd_way(upd_way), .upd_vaddr(upd_vaddr),
        .upd_paddr(upd_paddr), .upd_valid(upd_valid), .upd_dirty(upd_dirty),
        .upd_lock(upd_lock), .upd_line(upd_line), .inv_start(inv_start),
        .en_req(en_req), .dis_req(dis_req), .hit(hit), .hit_way(hit_way),
        .rd_data(rd_data), .mhit_err(mhit_err), .inv_busy(inv_busy),
        .inv_done(inv_done), .cache_on(cache_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] tag_fn(int s, int w);
        return 20'(s * 37 + w * 911 + 5);
    endfunction

    function automatic logic [63:0] dw_fn(int s, int w, int n);
        return {8'hC3, 8'(s), 8'(w), 8'(n), 32'(s * 1000 + w * 100 + n + 7)};
    endfunction

    function automatic logic [255:0] line_fn(int s, int w);
        logic [255:0] l;
        for (int n = 0; n < 4; n++) l[64*n +: 64] = dw_fn(s, w, n);
        return l;
    endfunction

    // Big-endian layout: {bits 0..19, index 20..26, dword 27..28, offset 29..31}
    function automatic logic [0:31] mk_vaddr(int hi, int idx, int dw);
        return {20'(hi), 7'(idx), 2'(dw), 3'b101};
    endfunction

    function automatic logic [0:31] mk_paddr(logic [19:0] tag);
        return {tag, 12'h3C5};
    endfunction

    task automatic do_update(int s, int w, logic [19:0] tag, logic v, logic [255:0] line);
        @(negedge clk);
        upd_we    = 1'b1;
        upd_way   = WW'(w);
        upd_vaddr = mk_vaddr(s * 3 + 1, s, w);
        upd_paddr = mk_paddr(tag);
        upd_valid = v;
        upd_dirty = 1'b1;
        upd_lock  = 1'b1;
        upd_line  = line;
        @(negedge clk);
        upd_we = 1'b0;
    endtask

    task automatic lookup(int hi, int s, int dw, logic [19:0] tag);
        lk_vaddr = mk_vaddr(hi, s, dw);
        lk_paddr = mk_paddr(tag);
        #1;
    endtask

    task automatic pulse_en(bit e, bit d);
        @(negedge clk);
        en_req  = e;
        dis_req = d;
        @(negedge clk);
        en_req  = 1'b0;
        dis_req = 1'b0;
        #1;
    endtask

    // Sweep; optionally probes a hit lookup early in the sweep (R7).
    task automatic run_sweep(bit probe);
        int bc;
        @(negedge clk);
        inv_start = 1'b1;
        @(negedge clk);
        inv_start = 1'b0;
        bc = 0;
        while (inv_busy && bc < 1000) begin
            bc++;
            inv_start = (bc == 50);
            if (probe && bc == 10) begin
                #1;
                check("R7", "hit during sweep", 64'(hit), 64'd0);
            end
            @(negedge clk);
        end
        inv_start = 1'b0;
        check("R6", "busy cycle count", 64'(bc), 64'd128);
        check("R11", "restart ignored length", 64'(bc), 64'd128);
        check("R6", "done pulse", 64'(inv_done), 64'd1);
        @(negedge clk);
        check("R6", "done single cycle", 64'(inv_done), 64'd0);
    endtask

    initial begin
        rst = 1'b1; upd_we = 0; upd_way = '0; upd_vaddr = '0; upd_paddr = '0;
        upd_valid = 0; upd_dirty = 0; upd_lock = 0; upd_line = '0;
        inv_start = 0; en_req = 0; dis_req = 0; lk_vaddr = '0; lk_paddr = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R10", "cache_on after reset", 64'(cache_on), 64'd0);
        check("R10", "busy after reset", 64'(inv_busy), 64'd0);
        check("R10", "done after reset", 64'(inv_done), 64'd0);
        check("R7", "hit after reset", 64'(hit), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        pulse_en(1, 0);
        check("R8", "enable before sweep ignored", 64'(cache_on), 64'd0);

        run_sweep(0);
        pulse_en(1, 0);
        check("R8", "enable after sweep", 64'(cache_on), 64'd1);

        for (int s = 0; s < 128; s++) begin
            lookup(s, s, 0, tag_fn(s, 0));
            check("R6", "miss after sweep", 64'(hit), 64'd0);
        end

        for (int s = 0; s < 128; s++)
            for (int w = 0; w < WAYS; w++)
                do_update(s, w, tag_fn(s, w), 1'b1, line_fn(s, w));

        for (int s = 0; s < 128; s++)
            for (int w = 0; w < WAYS; w++)
                for (int n = 0; n < 4; n++) begin
                    lookup(s * 13 + w * 7 + n * 1000, s, n, tag_fn(s, w));
                    check("R3", "hit", 64'(hit), 64'd1);
                    check("R3", "hit_way", 64'(hit_way), 64'(w));
                    check("R4", "doubleword", rd_data, dw_fn(s, w, n));
                    check("R5", "no multi-hit", 64'(mhit_err), 64'd0);
                end

        for (int s = 0; s < 128; s++) begin
            lookup(s, s, 1, tag_fn(s, 0) ^ 20'h80000);
            check("R2", "wrong tag miss", 64'(hit), 64'd0);
            check("R3", "miss data zero", rd_data, 64'd0);
            lookup(s, s, 1, tag_fn((s + 1) % 128, 0));
            check("R1", "other set tag miss", 64'(hit), 64'd0);
        end

        do_update(5, 2, tag_fn(5, 2), 1'b0, line_fn(5, 2));
        lookup(0, 5, 0, tag_fn(5, 2));
        check("R2", "invalid line miss", 64'(hit), 64'd0);
        do_update(5, 2, 20'hABCDE, 1'b1, line_fn(77, 3));
        lookup(0, 5, 3, 20'hABCDE);
        check("R12", "new tag hit", 64'(hit), 64'd1);
        check("R12", "new tag way", 64'(hit_way), 64'd2);
        check("R12", "new data", rd_data, dw_fn(77, 3, 3));

        do_update(9, 3, tag_fn(9, 1), 1'b1, line_fn(9, 3));
        lookup(0, 9, 2, tag_fn(9, 1));
        check("R5", "multi-hit flag", 64'(mhit_err), 64'd1);
        check("R5", "lowest way", 64'(hit_way), 64'd1);
        check("R5", "lowest way data", rd_data, dw_fn(9, 1, 2));
        do_update(9, 0, tag_fn(9, 1), 1'b1, line_fn(9, 0));
        lookup(0, 9, 2, tag_fn(9, 1));
        check("R5", "way 0 wins", 64'(hit_way), 64'd0);
        check("R5", "way 0 data", rd_data, dw_fn(9, 0, 2));

        lookup(0, 20, 1, tag_fn(20, 3));
        pulse_en(0, 1);
        check("R9", "disable", 64'(cache_on), 64'd0);
        check("R7", "hit while off", 64'(hit), 64'd0);
        pulse_en(1, 1);
        check("R9", "disable beats enable", 64'(cache_on), 64'd0);
        pulse_en(1, 0);
        check("R8", "re-enable", 64'(cache_on), 64'd1);
        check("R3", "hit after re-enable", 64'(hit), 64'd1);

        lookup(0, 100, 0, tag_fn(100, 1));
        check("R3", "pre-sweep hit", 64'(hit), 64'd1);
        run_sweep(1);
        lookup(0, 100, 0, tag_fn(100, 1));
        check("R6", "cleared by sweep", 64'(hit), 64'd0);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pulse_en(1, 0);
        check("R10", "sweep record cleared", 64'(cache_on), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule